// File: doc/BRIEF.md
# Load-Hit Speculative Issue Tracker

The block sits beside an instruction issue queue. It follows the speculative shadow of an integer load: consumers may leave the queue in the two cycles after a load issues, before anyone knows whether the load hit the data cache. Every entry that issues inside that shadow is held and has its request inhibited. This applies whether or not the entry uses the load's result. When the load's cache outcome arrives, all held entries are dequeued together on a hit. On a miss they are aborted together and their inhibit drops, so they can request issue again.

Entries that issue outside the shadow are retired from the queue at once with a dequeue pulse. Only one load shadow is tracked at a time. A second load that issues while a shadow is open does not open a window of its own. The cache outcome is expected a fixed number of cycles after the load issues, 3 by default, which matches a three-cycle load-to-use latency.

Top module: `load_shadow_tracker`

## Requirements
- R1: After reset, `inhibitMask`, `dequeueMask` and `abortMask` are all zero and `shadowBusy` is low.
- R2: A `loadIssue` accepted while `shadowBusy` is low raises `shadowBusy` from the next cycle. `shadowBusy` stays high until a resolution is accepted and drops in the cycle after that resolution.
- R3: An issue (`issueValid` with `issueId`) in either of the two cycles after the load's issue cycle sets bit `issueId` of `inhibitMask` from the next cycle, with no dequeue pulse. This holds regardless of whether the entry depends on the load.
- R4: An issue outside the window gives a one-cycle pulse on bit `issueId` of `dequeueMask` in the next cycle and no inhibit. Outside the window means: with no shadow open, in the load's own issue cycle, or later than the second cycle after the load.
- R5: A resolution is accepted when `resolveValid` is high, `resolveTag` equals the tracked load's tag and at least `RESOLVE_LAT` cycles have passed since the load issued. If it is accepted with `resolveHit` = 1, the next cycle shows every held entry's bit in `dequeueMask` for one cycle, `abortMask` is zero, and `inhibitMask` is cleared in that same cycle.
- R6: An accepted resolution with `resolveHit` = 0 gives every held entry's bit in `abortMask` for one cycle in the next cycle. In that cycle those bits are absent from `dequeueMask` and `inhibitMask` is cleared.
- R7: A resolution is ignored, leaving all masks and `shadowBusy` unchanged, in any of these cases: no shadow is open, the tag differs, or it comes before `RESOLVE_LAT` cycles have passed.
- R8: A `loadIssue` while `shadowBusy` is high is ignored. No new window opens, and only the first load's tag resolves the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadIssue | input | 1 | An integer load issues this cycle |
| loadTag | input | TAG_W | Tag of the issuing load |
| issueValid | input | 1 | A queue entry issues this cycle |
| issueId | input | ID_W | Index of the issuing entry |
| resolveValid | input | 1 | A load cache outcome is presented |
| resolveTag | input | TAG_W | Tag of the load being resolved |
| resolveHit | input | 1 | 1 = cache hit, 0 = miss |
| inhibitMask | output | NUM_ENTRIES | One-hot per entry: request inhibited, held in shadow |
| dequeueMask | output | NUM_ENTRIES | One-cycle per-entry strobe: remove entry from queue |
| abortMask | output | NUM_ENTRIES | One-cycle per-entry strobe: cancel execution, re-arm request |
| shadowBusy | output | 1 | A load shadow is being tracked |

## Verification
A wrong window count would show one cycle after a consumer issues. That entry would appear in `dequeueMask` where `inhibitMask` was expected, or the reverse, so the tests issue entries in the load's own cycle, in both window cycles and just after the window. A stale speculative mark stays visible on `inhibitMask` with nothing to clear it. The cycle after a resolution therefore has to show the whole held set moved onto exactly one of the two strobes while `inhibitMask` returns to zero. A bad tag or timing comparison would show as `shadowBusy` dropping early, or as the held entries being released by a resolution that should have been ignored.

// File: rtl/lst_pkg.sv
package lst_pkg;
  // Strobes the control half sends to the per-entry datapath each cycle
  typedef struct packed {
    logic markSpec;     // issuing entry lands inside the shadow window
    logic plainDeq;     // issuing entry retires immediately
    logic resolveHit;   // held entries leave the queue
    logic resolveMiss;  // held entries are cancelled and re-armed
  } lstStrobe_t;
endpackage

// File: rtl/lst_ctrl.sv
module lst_ctrl
  import lst_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int WIN_LEN     = 2,
  parameter int RESOLVE_LAT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIssue,
  input  logic [TAG_W-1:0] loadTag,
  input  logic             issueValid,
  input  logic             resolveValid,
  input  logic [TAG_W-1:0] resolveTag,
  input  logic             resolveHit,
  output lstStrobe_t       strobe,
  output logic             busy
);
  localparam int AGE_W = $clog2(RESOLVE_LAT + 1);
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);
  localparam logic [AGE_W-1:0] AGE_WIN = AGE_W'(WIN_LEN);
  localparam logic [AGE_W-1:0] AGE_RES = AGE_W'(RESOLVE_LAT);

  logic             busyQ;
  logic [TAG_W-1:0] tagQ;
  logic [AGE_W-1:0] ageQ;   // cycles since the tracked load issued
  logic             resolveAcc;
  logic             inWindow;

  assign resolveAcc = busyQ && resolveValid && (resolveTag == tagQ) && (ageQ >= AGE_RES);
  assign inWindow   = busyQ && (ageQ >= AGE_ONE) && (ageQ <= AGE_WIN) && !resolveAcc;

  always_comb begin
    strobe.markSpec    = issueValid && inWindow;
    strobe.plainDeq    = issueValid && !inWindow;
    strobe.resolveHit  = resolveAcc && resolveHit;
    strobe.resolveMiss = resolveAcc && !resolveHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      tagQ  <= '0;
      ageQ  <= '0;
    end else if (!busyQ) begin
      if (loadIssue) begin
        busyQ <= 1'b1;
        tagQ  <= loadTag;
        ageQ  <= AGE_ONE;
      end
    end else if (resolveAcc) begin
      busyQ <= 1'b0;
      ageQ  <= '0;
    end else if (ageQ < AGE_RES) begin
      ageQ <= ageQ + AGE_ONE;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/lst_dpath.sv
module lst_dpath
  import lst_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ID_W        = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lstStrobe_t             strobe,
  input  logic [ID_W-1:0]        issueId,
  output logic [NUM_ENTRIES-1:0] inhibitMask,
  output logic [NUM_ENTRIES-1:0] dequeueMask,
  output logic [NUM_ENTRIES-1:0] abortMask
);
  logic [NUM_ENTRIES-1:0] specQ;
  logic [NUM_ENTRIES-1:0] deqQ;
  logic [NUM_ENTRIES-1:0] abortQ;
  logic                   resolveAny;

  assign resolveAny = strobe.resolveHit | strobe.resolveMiss;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    logic selfHit;
    assign selfHit = (issueId == ID_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        specQ[i]  <= 1'b0;
        deqQ[i]   <= 1'b0;
        abortQ[i] <= 1'b0;
      end else begin
        specQ[i]  <= (specQ[i] & ~resolveAny) | (strobe.markSpec & selfHit);
        deqQ[i]   <= (strobe.plainDeq & selfHit) | (strobe.resolveHit & specQ[i]);
        abortQ[i] <= strobe.resolveMiss & specQ[i];
      end
    end
  end

  assign inhibitMask = specQ;
  assign dequeueMask = deqQ;
  assign abortMask   = abortQ;
endmodule

// File: rtl/load_shadow_tracker.sv
module load_shadow_tracker
  import lst_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 4,
  parameter int WIN_LEN     = 2,
  parameter int RESOLVE_LAT = 3,
  localparam int ID_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadIssue,
  input  logic [TAG_W-1:0]       loadTag,
  input  logic                   issueValid,
  input  logic [ID_W-1:0]        issueId,
  input  logic                   resolveValid,
  input  logic [TAG_W-1:0]       resolveTag,
  input  logic                   resolveHit,
  output logic [NUM_ENTRIES-1:0] inhibitMask,
  output logic [NUM_ENTRIES-1:0] dequeueMask,
  output logic [NUM_ENTRIES-1:0] abortMask,
  output logic                   shadowBusy
);
  lstStrobe_t strobe;

  lst_ctrl #(
    .TAG_W(TAG_W), .WIN_LEN(WIN_LEN), .RESOLVE_LAT(RESOLVE_LAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .loadIssue(loadIssue), .loadTag(loadTag),
    .issueValid(issueValid), .resolveValid(resolveValid),
    .resolveTag(resolveTag), .resolveHit(resolveHit),
    .strobe(strobe), .busy(shadowBusy)
  );

  lst_dpath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ID_W(ID_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueId(issueId),
    .inhibitMask(inhibitMask), .dequeueMask(dequeueMask), .abortMask(abortMask)
  );
endmodule

// File: rtl/lst_checker.sv
module lst_checker #(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_ENTRIES-1:0] inhibitMask,
  input logic [NUM_ENTRIES-1:0] dequeueMask,
  input logic [NUM_ENTRIES-1:0] abortMask,
  input logic                   shadowBusy
);
  AST_HELD_NEEDS_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitMask != '0) |-> shadowBusy);  // R3

  AST_NEW_HOLD_IN_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    ((inhibitMask & ~$past(inhibitMask)) != '0) |-> $past(shadowBusy));  // R3

  AST_ABORT_WAS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (abortMask != '0) |-> ((abortMask & ~$past(inhibitMask)) == '0));  // R6

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (abortMask != '0) |-> ((inhibitMask == '0) && !shadowBusy));  // R6

  AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (dequeueMask & abortMask) == '0);  // R5

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (abortMask != '0) |=> (abortMask == '0));  // R6

  AST_HOLD_RELEASE_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shadowBusy) |-> (inhibitMask == '0));  // R5
endmodule

bind load_shadow_tracker lst_checker #(.NUM_ENTRIES(NUM_ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .inhibitMask(inhibitMask), .dequeueMask(dequeueMask),
  .abortMask(abortMask), .shadowBusy(shadowBusy)
);

// File: tb/sim_load_shadow_tracker.sv
module sim_load_shadow_tracker;
  localparam int N = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadIssue = 1'b0;
  logic [TW-1:0] loadTag = '0;
  logic issueValid = 1'b0;
  logic [3:0] issueId = '0;
  logic resolveValid = 1'b0;
  logic [TW-1:0] resolveTag = '0;
  logic resolveHit = 1'b0;
  logic [N-1:0] inhibitMask, dequeueMask, abortMask;
  logic shadowBusy;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  load_shadow_tracker u0 (
    .clk(clk), .rstN(rstN), .loadIssue(loadIssue), .loadTag(loadTag),
    .issueValid(issueValid), .issueId(issueId), .resolveValid(resolveValid),
    .resolveTag(resolveTag), .resolveHit(resolveHit), .inhibitMask(inhibitMask),
    .dequeueMask(dequeueMask), .abortMask(abortMask), .shadowBusy(shadowBusy)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle();
    loadIssue = 0; issueValid = 0; resolveValid = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] bitOf(input int i);
    return N'(1) << i;
  endfunction

  task automatic testReset();
    chk("R1 inhibit after reset", 32'(inhibitMask), 0);
    chk("R1 dequeue after reset", 32'(dequeueMask), 0);
    chk("R1 abort after reset", 32'(abortMask), 0);
    chk("R1 busy after reset", 32'(shadowBusy), 0);
  endtask

  task automatic testPlain();
    idle(); issueValid = 1; issueId = 4; step();
    idle();
    chk("R4 idle issue dequeue", 32'(dequeueMask), 32'(bitOf(4)));
    chk("R4 idle issue no inhibit", 32'(inhibitMask), 0);
    step();
    chk("R4 dequeue lasts one cycle", 32'(dequeueMask), 0);
  endtask

  task automatic testHit();
    // load cycle L, with a plain issue in the same cycle
    loadIssue = 1; loadTag = 5; issueValid = 1; issueId = 12; step();
    // L+1
    loadIssue = 0;
    chk("R2 busy after load", 32'(shadowBusy), 1);
    chk("R4 load-cycle issue dequeued", 32'(dequeueMask), 32'(bitOf(12)));
    chk("R4 load-cycle issue not held", 32'(inhibitMask), 0);
    issueValid = 1; issueId = 3; step();
    // L+2
    chk("R3 first window issue held", 32'(inhibitMask), 32'(bitOf(3)));
    chk("R3 no dequeue for held entry", 32'(dequeueMask), 0);
    issueValid = 1; issueId = 7; step();
    // L+3: resolution plus an issue past the window
    chk("R3 second window issue held", 32'(inhibitMask), 32'(bitOf(3) | bitOf(7)));
    issueValid = 1; issueId = 9;
    resolveValid = 1; resolveTag = 5; resolveHit = 1; step();
    // L+4
    idle();
    chk("R5 hit dequeues held set", 32'(dequeueMask), 32'(bitOf(3) | bitOf(7) | bitOf(9)));
    chk("R5 hit clears inhibit", 32'(inhibitMask), 0);
    chk("R5 no abort on hit", 32'(abortMask), 0);
    chk("R2 busy drops after resolve", 32'(shadowBusy), 0);
    step();
    chk("R5 dequeue pulse ends", 32'(dequeueMask), 0);
  endtask

  task automatic testMiss();
    loadIssue = 1; loadTag = 2; step();
    loadIssue = 0; issueValid = 1; issueId = 0; step();
    issueValid = 1; issueId = 15; step();
    issueValid = 0;
    chk("R3 held set before miss", 32'(inhibitMask), 32'(bitOf(0) | bitOf(15)));
    resolveValid = 1; resolveTag = 2; resolveHit = 0; step();
    idle();
    chk("R6 miss aborts held set", 32'(abortMask), 32'(bitOf(0) | bitOf(15)));
    chk("R6 miss no dequeue", 32'(dequeueMask), 0);
    chk("R6 miss clears inhibit", 32'(inhibitMask), 0);
    step();
    chk("R6 abort pulse ends", 32'(abortMask), 0);
  endtask

  task automatic testIgnoredResolve();
    idle(); resolveValid = 1; resolveTag = 1; resolveHit = 0; step();
    idle();
    chk("R7 idle resolve no busy", 32'(shadowBusy), 0);
    chk("R7 idle resolve no abort", 32'(abortMask), 0);
    loadIssue = 1; loadTag = 9; step();                    // L
    loadIssue = 0; issueValid = 1; issueId = 6;            // L+1
    resolveValid = 1; resolveTag = 9; resolveHit = 1; step();
    issueValid = 0; step();                                // L+2 early resolve dropped
    chk("R7 early resolve keeps hold", 32'(inhibitMask), 32'(bitOf(6)));
    chk("R7 early resolve no dequeue", 32'(dequeueMask), 0);
    resolveValid = 1; resolveTag = 8; resolveHit = 1; step();  // L+3 wrong tag
    resolveValid = 0;
    chk("R7 wrong tag keeps busy", 32'(shadowBusy), 1);
    chk("R7 wrong tag keeps hold", 32'(inhibitMask), 32'(bitOf(6)));
    resolveValid = 1; resolveTag = 9; resolveHit = 1; step();  // late, correct
    idle();
    chk("R5 late correct resolve dequeues", 32'(dequeueMask), 32'(bitOf(6)));
    chk("R2 busy drops after late resolve", 32'(shadowBusy), 0);
  endtask

  task automatic testLoadWhileBusy();
    loadIssue = 1; loadTag = 1; step();                     // L
    loadIssue = 1; loadTag = 6; issueValid = 1; issueId = 1; step();  // L+1
    loadIssue = 0; issueValid = 0; step();                  // L+2
    issueValid = 1; issueId = 2;                            // L+3 past window
    resolveValid = 1; resolveTag = 6; resolveHit = 1; step();
    idle();
    chk("R8 second load opens no window", 32'(dequeueMask), 32'(bitOf(2)));
    chk("R8 second tag does not resolve", 32'(inhibitMask), 32'(bitOf(1)));
    chk("R8 still busy", 32'(shadowBusy), 1);
    resolveValid = 1; resolveTag = 1; resolveHit = 1; step();
    idle();
    chk("R8 first tag resolves", 32'(dequeueMask), 32'(bitOf(1)));
    chk("R8 busy clears", 32'(shadowBusy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testPlain();
    testHit();
    testMiss();
    testIgnoredResolve();
    testLoadWhileBusy();
    step();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule